// File: doc/BRIEF.md
# TLB Reload Register Unit

This block is the hardware helper that sits beside a software miss handler for a small, fully associative data TLB. It holds five registers behind a simple register port: the pending effective page, the first-level table base, the second-level descriptor, the real page and the reload control. When the handler reads either table-base register, it does not get the raw base back. It gets a ready-made page-table entry address, formed from that base and the pending effective page. The handler therefore spends no instructions on masking and shifting.

Writing the real-page register is the commit point. One write builds a full TLB entry from the written value, the pending effective page and the current second-level descriptor. The entry goes into the 32-entry array at the slot named by the control register. The slot index then steps down by one, so the next reload lands in a different slot. A reserve flag keeps the lowest four slots out of that rotation. A miss reporter outside the block loads the effective-page register with the faulting page. A read-only entry port lets the surrounding logic inspect any stored entry.

Top module: `tlb_reload_unit`

## Requirements
- R1: After reset the following hold. `regReady` is 1 and `rdValid` is 0. The effective-page, level-1, level-2 and real-page registers read as 0. The control register reads with index 31 and the reserve flag clear. Every array entry has `entValid`=0 and `entSvalid`=0.
- R2: An access is accepted on a rising edge where `regReq` and `regReady` are both 1.
  - After an accepted write, `regReady` is 0 for exactly the following cycle.
  - An accepted read leaves `regReady` at 1.
  - The read result appears on `regRdata` with `rdValid`=1 in the cycle after acceptance.
- R3: Register select codes are 0 effective page, 1 level-1 base, 2 level-2 descriptor, 3 real page and 4 control. Writes to codes 5-7 change nothing, and reads of them return 0.
- R4: The effective-page register (code 0) keeps only three fields:
  - page number in bits 31:12;
  - valid flag in bit 9;
  - address-space ID in bits 3:0.
  All other bits read 0.
- R5: A cycle with `missValid`=1 loads the effective-page register with `missAddr[31:12]`, valid=1 and `missAsid`. A register write to code 0 in the same cycle takes precedence over the miss.
- R6: Reading code 1 returns {base[31:12], page[19:10], 2'b00}. Here base is the last written level-1 value and page is the pending effective page number.
- R7: Reading code 2 returns {l2[31:12], 12'h000} + {page[9:0], 2'b00}.
- R8: A write to code 3 creates an entry at the current control index with these fields:
  - epn, valid and asid from the effective-page register;
  - rpn from data bits 31:12;
  - small16k from data bit 3;
  - apg from level-2 bits 8:5;
  - guarded from bit 4;
  - ps from bits 3:2;
  - wt from bit 1;
  - svalid from bit 0.
  Reading code 3 returns the last written value.
- R9: The page-size codes are 11 for 8M, 01 for 512K and 00 for the small size. Within the small size, small16k picks 16K (1) or 4K (0). The entry keeps both fields exactly as supplied, for every combination.
- R10: The control register (code 4) holds the entry index in bits 12:8 and the reserve flag in bit 27. All other bits read 0.
- R11: After each entry creation the index decreases by one. It wraps to 31 instead of going below 0.
- R12: With the reserve flag set, an index at or below 4 wraps to 31 after a creation. Entries 0-3 are then never written unless software places the index there itself.
- R13: The entry port shows the stored fields of entry `tlbIdx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regReq | input | 1 | Register access request |
| regWr | input | 1 | 1 = write, 0 = read |
| regSel | input | 3 | Register select code |
| regWdata | input | 32 | Write data |
| regReady | output | 1 | Access can be accepted this cycle |
| rdValid | output | 1 | Read data valid |
| regRdata | output | 32 | Read data |
| missValid | input | 1 | Miss report strobe |
| missAddr | input | 32 | Faulting effective address |
| missAsid | input | 4 | Address-space ID of the miss |
| tlbIdx | input | 5 | Entry to display |
| entEpn | output | 20 | Entry effective page number |
| entValid | output | 1 | Entry valid flag |
| entAsid | output | 4 | Entry address-space ID |
| entRpn | output | 20 | Entry real page number |
| entApg | output | 4 | Entry access group |
| entGuarded | output | 1 | Entry guarded flag |
| entPs | output | 2 | Entry page-size code |
| entSmall16k | output | 1 | Entry 16K-within-small flag |
| entWt | output | 1 | Entry write-through flag |
| entSvalid | output | 1 | Entry segment-valid flag |

## Verification
The address-assist reads are checked with random effective pages and bases. These patterns show whether the correct address bits are routed to the index and offset fields, and whether the add is done instead of a plain overwrite. Entry creation is checked across a chain of reloads that crosses index 0, once with the reserve flag clear and once with it set. This chain tells a correct wrap point apart from an off-by-one, and shows that reserved slots are left untouched. Further directed patterns cover three cases: all-ones writes, which expose field masking; a miss colliding with a register write, which shows the precedence; and size-code and 16K-flag combinations, which show that the fields are kept separate.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

  typedef enum logic [2:0] {
    SEL_EPN = 3'd0,
    SEL_L1  = 3'd1,
    SEL_L2  = 3'd2,
    SEL_RPN = 3'd3,
    SEL_CTL = 3'd4
  } regSel_e;

  typedef struct packed {
    logic [19:0] epn;
    logic        valid;
    logic [3:0]  asid;
    logic [19:0] rpn;
    logic [3:0]  apg;
    logic        guarded;
    logic [1:0]  ps;
    logic        small16k;
    logic        wt;
    logic        svalid;
  } tlbEntry_t;

  typedef struct packed {
    logic       wrEpn;
    logic       wrL1;
    logic       wrL2;
    logic       wrRpn;
    logic       wrCtl;
    logic       rdLoad;
    logic [2:0] rdSel;
  } regStrobe_t;

endpackage

// File: rtl/tlbr_ctrl.sv
module tlbr_ctrl
  import tlbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regReq,
  input  logic       regWr,
  input  logic [2:0] regSel,
  output logic       regReady,
  output logic       rdValid,
  output regStrobe_t strb
);

  logic busy;
  logic accept;

  assign regReady = !busy;
  assign accept   = regReq && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      busy    <= accept && regWr;
      rdValid <= accept && !regWr;
    end
  end

  always_comb begin
    strb        = '0;
    strb.rdLoad = accept && !regWr;
    strb.rdSel  = regSel;
    if (accept && regWr) begin
      case (regSel_e'(regSel))
        SEL_EPN: strb.wrEpn = 1'b1;
        SEL_L1:  strb.wrL1  = 1'b1;
        SEL_L2:  strb.wrL2  = 1'b1;
        SEL_RPN: strb.wrRpn = 1'b1;
        SEL_CTL: strb.wrCtl = 1'b1;
        default: ;
      endcase
    end
  end

  assert_write_serial_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWr && regReady) |=> !regReady);

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWr && regReady) |=> (rdValid && regReady));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEpn, strb.wrL1, strb.wrL2, strb.wrRpn, strb.wrCtl}));

endmodule

// File: rtl/tlbr_dp.sv
module tlbr_dp
  import tlbr_pkg::*;
#(
  parameter int NUM_ENTRIES  = 32,
  parameter int NUM_RESERVED = 4,
  parameter int IDX_W        = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [31:0]      wdata,
  input  logic             missValid,
  input  logic [31:0]      missAddr,
  input  logic [3:0]       missAsid,
  output logic [31:0]      rdata,
  output logic             wrEn,
  output logic [IDX_W-1:0] wIdx,
  output tlbEntry_t        wEntry
);

  localparam int IDX_LSB = 8;
  localparam int RSV_BIT = 27;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] RES_LOW  = IDX_W'(NUM_RESERVED);

  logic [19:0]      epnPage;
  logic             epnValid;
  logic [3:0]       epnAsid;
  logic [19:0]      l1Base;
  logic [31:0]      l2Word;
  logic [31:0]      rpnWord;
  logic             rsvFlag;
  logic [IDX_W-1:0] curIdx;

  logic [IDX_W-1:0] lowBound;
  logic [IDX_W-1:0] nextIdx;
  logic [31:0]      l1Addr;
  logic [31:0]      l2Addr;
  logic [31:0]      ctlWord;
  logic [31:0]      rdMux;

  assign lowBound = rsvFlag ? RES_LOW : '0;
  assign nextIdx  = (curIdx <= lowBound) ? LAST_IDX : curIdx - 1'b1;

  assign l1Addr = {l1Base, epnPage[19:10], 2'b00};
  assign l2Addr = {l2Word[31:12], 12'h000} + {20'h0, epnPage[9:0], 2'b00};

  always_comb begin
    ctlWord                      = '0;
    ctlWord[RSV_BIT]             = rsvFlag;
    ctlWord[IDX_LSB +: IDX_W]    = curIdx;
  end

  always_comb begin
    case (regSel_e'(strb.rdSel))
      SEL_EPN: rdMux = {epnPage, 2'b00, epnValid, 5'b00000, epnAsid};
      SEL_L1:  rdMux = l1Addr;
      SEL_L2:  rdMux = l2Addr;
      SEL_RPN: rdMux = rpnWord;
      SEL_CTL: rdMux = ctlWord;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epnPage  <= '0;
      epnValid <= 1'b0;
      epnAsid  <= '0;
      l1Base   <= '0;
      l2Word   <= '0;
      rpnWord  <= '0;
      rsvFlag  <= 1'b0;
      curIdx   <= LAST_IDX;
      rdata    <= '0;
    end else begin
      if (strb.wrEpn) begin
        epnPage  <= wdata[31:12];
        epnValid <= wdata[9];
        epnAsid  <= wdata[3:0];
      end else if (missValid) begin
        epnPage  <= missAddr[31:12];
        epnValid <= 1'b1;
        epnAsid  <= missAsid;
      end
      if (strb.wrL1) l1Base <= wdata[31:12];
      if (strb.wrL2) l2Word <= wdata;
      if (strb.wrRpn) begin
        rpnWord <= wdata;
        curIdx  <= nextIdx;
      end
      if (strb.wrCtl) begin
        rsvFlag <= wdata[RSV_BIT];
        curIdx  <= wdata[IDX_LSB +: IDX_W];
      end
      if (strb.rdLoad) rdata <= rdMux;
    end
  end

  assign wrEn = strb.wrRpn;
  assign wIdx = curIdx;

  always_comb begin
    wEntry.epn      = epnPage;
    wEntry.valid    = epnValid;
    wEntry.asid     = epnAsid;
    wEntry.rpn      = wdata[31:12];
    wEntry.small16k = wdata[3];
    wEntry.apg      = l2Word[8:5];
    wEntry.guarded  = l2Word[4];
    wEntry.ps       = l2Word[3:2];
    wEntry.wt       = l2Word[1];
    wEntry.svalid   = l2Word[0];
  end

  assert_skip_reserved_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRpn && rsvFlag) |=> (curIdx >= RES_LOW));

  assert_index_moves_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRpn && !strb.wrCtl) |=> (curIdx != $past(curIdx)));

  assert_miss_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !strb.wrEpn) |=> (epnPage == $past(missAddr[31:12]) && epnValid));

endmodule

// File: rtl/tlbr_array.sv
module tlbr_array
  import tlbr_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wIdx,
  input  tlbEntry_t        wEntry,
  input  logic [IDX_W-1:0] rIdx,
  output tlbEntry_t        rEntry
);

  tlbEntry_t mem [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        mem[i] <= '0;
      else if (wrEn && (wIdx == IDX_W'(i)))
        mem[i] <= wEntry;
    end
  end

  assign rEntry = mem[rIdx];

  assert_entry_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (mem[$past(wIdx)] == $past(wEntry)));

endmodule

// File: rtl/tlb_reload_unit.sv
module tlb_reload_unit
  import tlbr_pkg::*;
#(
  parameter int NUM_ENTRIES  = 32,
  parameter int NUM_RESERVED = 4,
  parameter int IDX_W        = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regReq,
  input  logic             regWr,
  input  logic [2:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic             regReady,
  output logic             rdValid,
  output logic [31:0]      regRdata,
  input  logic             missValid,
  input  logic [31:0]      missAddr,
  input  logic [3:0]       missAsid,
  input  logic [IDX_W-1:0] tlbIdx,
  output logic [19:0]      entEpn,
  output logic             entValid,
  output logic [3:0]       entAsid,
  output logic [19:0]      entRpn,
  output logic [3:0]       entApg,
  output logic             entGuarded,
  output logic [1:0]       entPs,
  output logic             entSmall16k,
  output logic             entWt,
  output logic             entSvalid
);

  regStrobe_t       strb;
  logic             wrEn;
  logic [IDX_W-1:0] wIdx;
  tlbEntry_t        wEntry;
  tlbEntry_t        rEntry;

  tlbr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regReq   (regReq),
    .regWr    (regWr),
    .regSel   (regSel),
    .regReady (regReady),
    .rdValid  (rdValid),
    .strb     (strb)
  );

  tlbr_dp #(
    .NUM_ENTRIES  (NUM_ENTRIES),
    .NUM_RESERVED (NUM_RESERVED),
    .IDX_W        (IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (regWdata),
    .missValid (missValid),
    .missAddr  (missAddr),
    .missAsid  (missAsid),
    .rdata     (regRdata),
    .wrEn      (wrEn),
    .wIdx      (wIdx),
    .wEntry    (wEntry)
  );

  tlbr_array #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) uArray (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wIdx   (wIdx),
    .wEntry (wEntry),
    .rIdx   (tlbIdx),
    .rEntry (rEntry)
  );

  assign entEpn      = rEntry.epn;
  assign entValid    = rEntry.valid;
  assign entAsid     = rEntry.asid;
  assign entRpn      = rEntry.rpn;
  assign entApg      = rEntry.apg;
  assign entGuarded  = rEntry.guarded;
  assign entPs       = rEntry.ps;
  assign entSmall16k = rEntry.small16k;
  assign entWt       = rEntry.wt;
  assign entSvalid   = rEntry.svalid;

endmodule

// File: tb/sim_tlb_reload_unit.sv
module sim_tlb_reload_unit;
  import tlbr_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0, regWr = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        regReady, rdValid;
  logic [31:0] regRdata;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic [3:0]  missAsid = '0;
  logic [4:0]  tlbIdx = '0;
  logic [19:0] entEpn, entRpn;
  logic        entValid, entGuarded, entSmall16k, entWt, entSvalid;
  logic [3:0]  entAsid, entApg;
  logic [1:0]  entPs;

  int total = 0;
  int bad = 0;
  bit done = 0;

  tlbEntry_t expMem [32];
  logic [4:0] expIdx;
  logic       expRsv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_reload_unit u0 (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regReady(regReady), .rdValid(rdValid), .regRdata(regRdata),
    .missValid(missValid), .missAddr(missAddr), .missAsid(missAsid), .tlbIdx(tlbIdx),
    .entEpn(entEpn), .entValid(entValid), .entAsid(entAsid), .entRpn(entRpn),
    .entApg(entApg), .entGuarded(entGuarded), .entPs(entPs), .entSmall16k(entSmall16k),
    .entWt(entWt), .entSvalid(entSvalid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    while (!regReady) @(negedge clk);
    regReq = 1'b1; regWr = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regReq = 1'b0; regWr = 1'b0;
    check("R2 ready low after write", {63'b0, regReady}, 64'd0);
  endtask

  task automatic regRead(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    while (!regReady) @(negedge clk);
    regReq = 1'b1; regWr = 1'b0; regSel = sel;
    @(negedge clk);
    regReq = 1'b0;
    check("R2 rdValid/ready after read", {62'b0, rdValid, regReady}, 64'd3);
    data = regRdata;
  endtask

  task automatic checkEntry(input string req, input int idx);
    tlbEntry_t got;
    tlbIdx = 5'(idx);
    #1;
    got = '{epn:entEpn, valid:entValid, asid:entAsid, rpn:entRpn, apg:entApg,
            guarded:entGuarded, ps:entPs, small16k:entSmall16k, wt:entWt, svalid:entSvalid};
    check(req, 64'(got), 64'(expMem[idx]));
  endtask

  function automatic logic [4:0] stepIdx(input logic [4:0] i, input logic rsv);
    logic [4:0] lo = rsv ? 5'd4 : 5'd0;
    return (i <= lo) ? 5'd31 : i - 5'd1;
  endfunction

  task automatic setCtl(input logic rsv, input logic [4:0] idx);
    regWrite(3'd4, (32'(rsv) << 27) | (32'(idx) << 8));
    expRsv = rsv; expIdx = idx;
  endtask

  task automatic createEntry(input string req, input logic [31:0] epnW,
                             input logic [31:0] l2W, input logic [31:0] rpnW);
    logic [31:0] rd;
    int at;
    regWrite(3'd0, epnW);
    regWrite(3'd2, l2W);
    regWrite(3'd3, rpnW);
    at = int'(expIdx);
    expMem[at] = '{epn:epnW[31:12], valid:epnW[9], asid:epnW[3:0], rpn:rpnW[31:12],
                   apg:l2W[8:5], guarded:l2W[4], ps:l2W[3:2], small16k:rpnW[3],
                   wt:l2W[1], svalid:l2W[0]};
    expIdx = stepIdx(expIdx, expRsv);
    checkEntry(req, at);
    regRead(3'd4, rd);
    check("R10 R11 control after create", 64'(rd), 64'((32'(expRsv) << 27) | (32'(expIdx) << 8)));
  endtask

  task automatic testReset();
    logic [31:0] rd;
    check("R1 ready", {63'b0, regReady}, 64'd1);
    check("R1 rdValid", {63'b0, rdValid}, 64'd0);
    for (int s = 0; s < 4; s++) begin
      regRead(3'(s), rd);
      check("R1 register zero", 64'(rd), 64'd0);
    end
    regRead(3'd4, rd);
    check("R1 control reset", 64'(rd), 64'h1F00);
    for (int i = 0; i < 32; i++) begin
      expMem[i] = '0;
      checkEntry("R1 entry clear", i);
    end
    expIdx = 5'd31; expRsv = 1'b0;
  endtask

  task automatic testFormats();
    logic [31:0] rd;
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd);
    check("R4 epn mask", 64'(rd), 64'hFFFF_F20F);
    regWrite(3'd4, 32'hFFFF_FFFF);
    regRead(3'd4, rd);
    check("R10 control mask", 64'(rd), 64'h0800_1F00);
    setCtl(1'b0, 5'd31);
    regWrite(3'd3, 32'hA5A5_1238);
    regRead(3'd3, rd);
    check("R8 rpn readback", 64'(rd), 64'hA5A5_1238);
    expMem[31] = '{epn:20'hFFFFF, valid:1'b1, asid:4'hF, rpn:20'hA5A51, apg:4'h0,
                   guarded:1'b0, ps:2'b00, small16k:1'b1, wt:1'b0, svalid:1'b0};
    expIdx = 5'd30;
    checkEntry("R8 entry from rpn write", 31);
    regRead(3'd0, rd);
    regWrite(3'd6, 32'h1234_5678);
    regRead(3'd0, rd);
    check("R3 unused write ignored", 64'(rd), 64'hFFFF_F20F);
    regRead(3'd6, rd);
    check("R3 unused read zero", 64'(rd), 64'd0);
    regRead(3'd4, rd);
    check("R3 control untouched", 64'(rd), 64'h1E00);
  endtask

  task automatic testAssist();
    logic [31:0] rd, base, l2, ea;
    for (int k = 0; k < 8; k++) begin
      base = $urandom(); l2 = $urandom(); ea = $urandom();
      regWrite(3'd1, base);
      regWrite(3'd2, l2);
      regWrite(3'd0, ea);
      regRead(3'd1, rd);
      check("R6 level-1 address", 64'(rd), 64'({base[31:12], ea[31:22], 2'b00}));
      regRead(3'd2, rd);
      check("R7 level-2 address", 64'(rd),
            64'({l2[31:12], 12'h000} + {20'h0, ea[21:12], 2'b00}));
    end
  endtask

  task automatic testMiss();
    logic [31:0] rd;
    @(negedge clk);
    missValid = 1'b1; missAddr = 32'hCAFE_B123; missAsid = 4'h6;
    @(negedge clk);
    missValid = 1'b0;
    regRead(3'd0, rd);
    check("R5 miss capture", 64'(rd), 64'hCAFE_B206);
    @(negedge clk);
    while (!regReady) @(negedge clk);
    regReq = 1'b1; regWr = 1'b1; regSel = 3'd0; regWdata = 32'h1111_1003;
    missValid = 1'b1; missAddr = 32'h9999_9000; missAsid = 4'hA;
    @(negedge clk);
    regReq = 1'b0; regWr = 1'b0; missValid = 1'b0;
    regRead(3'd0, rd);
    check("R5 write wins over miss", 64'(rd), 64'h1111_1003);
  endtask

  task automatic testChain();
    setCtl(1'b0, 5'd2);
    for (int k = 0; k < 5; k++)
      createEntry("R11 wrap chain", {20'(32'h10000 + k), 12'h200 | 12'(k)},
                  32'h0004_0000 | 32'((k * 37) & 9'h1FF), {20'(32'hB0000 + k), 12'h008});
  endtask

  task automatic testSizes();
    setCtl(1'b0, 5'd20);
    createEntry("R9 8M size", 32'h8000_0201, 32'h0000_000D, 32'h1230_0000);
    createEntry("R9 512K size", 32'h8100_0202, 32'h0000_0005, 32'h1240_0008);
    createEntry("R9 small 16K", 32'h8200_0203, 32'h0000_01F1, 32'h1250_0008);
    createEntry("R9 small 4K", 32'h8300_0204, 32'h0000_0013, 32'h1260_0000);
  endtask

  task automatic testReserve();
    setCtl(1'b1, 5'd5);
    createEntry("R12 reserved chain", 32'h7000_0201, 32'h0000_0021, 32'h7100_0000);
    createEntry("R12 reserved chain", 32'h7001_0202, 32'h0000_0041, 32'h7101_0000);
    check("R12 wrap skips reserved", 64'(expIdx), 64'd31);
    createEntry("R12 reserved chain", 32'h7002_0203, 32'h0000_0061, 32'h7102_0000);
    for (int i = 0; i < 4; i++) checkEntry("R12 reserved entries untouched", i);
    for (int i = 0; i < 32; i++) checkEntry("R13 entry port scan", i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFormats();
    testAssist();
    testMiss();
    testChain();
    testSizes();
    testReserve();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule